// File: doc/BRIEF.md
# Cross-domain double-buffered register bank

This block is the register front end of a peripheral whose counting core runs on its own clock. Software writes byte-wide registers on the bus clock. The compare values are held in bus-side staging bytes. They reach the core only as a whole set: either when the peripheral is switched on, or when a transfer command runs. Each crossing between the two clocks uses a toggle request and a toggle acknowledge, and each toggle passes through a two-flop synchronizer.

Software starts a transfer in one of three ways: an immediate command, an end-of-cycle command, or an auto-update. The auto-update fires on a write to the top byte of the last compare register while the auto-update mode bit is set. A core-side pulse input, `core_eoc`, marks the end of a core cycle and takes the place of the counter. A static mode byte can be changed only while the run bit reads 0. Two ready bits in the status byte tell software when the run bit and the command register may be written. Control and status pins are plain level signals. The block has no streaming data path, so it has no valid/ready back-pressure.

Address map. Address 0 holds the run bit in bit 0. Address 1 is the command register: bit 0 requests an immediate transfer and bit 1 an end-of-cycle transfer. Address 2 is the status byte: bit 0 is run-ready, bit 1 is command-ready, and bit 2 repeats the run bit. Address 3 is the mode byte, with auto-update in bit 0. Addresses 8 to 15 hold the compare bytes. Address 8+2k is the low byte and 9+2k the high byte of compare k, and `core_cmp[16k+15:16k]` carries compare k.

Top module: `xdom_regbank`

## Requirements
- R1: After reset the run bit reads 0, status reads 0x01, the command register reads 0, all shadows and staging bytes are 0, and `core_run` is 0.
- R2: A write to the run bit takes effect only while run-ready (status bit 0) is 1. Run-ready is 0 while a run change or a transfer command is in flight. A write at any other time leaves the run bit unchanged.
- R3: Writing run = 1 drops run-ready until the core has answered. The core then sets `core_run` and copies every staging byte into the shadows.
- R4: A compare byte write is accepted only while command-ready (status bit 1) is 1. Command-ready means run is 1 and no run change or command is in flight. A write while command-ready is 0 leaves the staging byte unchanged.
- R5: Writing 1 to command bit 0 copies the staging bytes into the shadows once the request reaches the core. Command-ready stays 0 until the acknowledge returns.
- R6: Writing 1 to command bit 1 leaves the shadows unchanged until the first `core_eoc` pulse after the request reaches the core. That pulse copies the staging bytes once. Command-ready stays 0 until the copy is acknowledged.
- R7: While mode bit 0 is 1, an accepted write to address 15 starts an end-of-cycle transfer. While mode bit 0 is 0, the same write starts nothing.
- R8: The command register reads back the requested transfer bit while that transfer is in flight and reads 0 once it completes. A command write while command-ready is 0 is ignored.
- R9: A write to the mode byte is ignored while the run bit reads 1.
- R10: Writing run = 0 clears `core_run` after the handshake, and the shadows keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| core_clk | input | 1 | Core-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe (bus clock) |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Combinational read data |
| core_eoc | input | 1 | End-of-core-cycle pulse (core clock) |
| core_run | output | 1 | Run state seen by the core |
| core_cmp | output | 64 | Core shadow compare values, four 16-bit fields |
| cfg_mode | output | 8 | Static mode byte |

## Verification
A register write lands on the bus edge after the strobe is driven, so the bench reads the register back half a bus cycle after that edge. Ready bits drop on that same edge. Shadows and `core_run` follow only after two core synchronizer flops and one core register, and the ready bits recover two bus flops after that. Because the two clocks are unrelated, the bench does not count a fixed delay here: it polls the ready bit within a bounded window and only then compares shadows against its model. For the end-of-cycle paths it idles the core for many cycles with `core_eoc` low and checks the shadows did not move, then pulses once and checks the copy.

// File: rtl/xdb_pkg.sv
package xdb_pkg;
  localparam int A_RUN    = 0;
  localparam int A_CMD    = 1;
  localparam int A_STAT   = 2;
  localparam int A_MODE   = 3;
  localparam int CMP_BASE = 8;

  typedef enum logic [1:0] {
    XF_NONE = 2'b00,
    XF_NOW  = 2'b01,
    XF_EOC  = 2'b10
  } xfer_e;
endpackage

// File: rtl/xdb_sync.sv
module xdb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/xdb_bus_side.sv
module xdb_bus_side
  import xdb_pkg::*;
#(
  parameter int NCMP   = 4,
  parameter int CMP_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  input  logic                  run_ack_s,
  input  logic                  xf_ack_s,
  output logic                  run_req,
  output logic                  xf_req,
  output logic                  run_q,
  output xfer_e                 xf_kind,
  output logic [NCMP*CMP_W-1:0] stage_flat,
  output logic [7:0]            mode_q
);
  localparam int NB    = CMP_W / 8;
  localparam int NBYTE = NCMP * NB;
  localparam int TRIG  = CMP_BASE + NBYTE - 1;

  logic [7:0] stage_q [NBYTE];
  logic run_busy, xf_busy, run_rdy, cmd_rdy;
  logic hit_run, hit_cmd, hit_mode, hit_trig;
  logic start_xf;
  xfer_e start_kind;

  assign run_busy = run_req ^ run_ack_s;
  assign xf_busy  = xf_req ^ xf_ack_s;
  assign run_rdy  = !run_busy && !xf_busy;
  assign cmd_rdy  = run_q && run_rdy;

  assign hit_run  = wr_en && (wr_addr == ADDR_W'(A_RUN));
  assign hit_cmd  = wr_en && (wr_addr == ADDR_W'(A_CMD));
  assign hit_mode = wr_en && (wr_addr == ADDR_W'(A_MODE));
  assign hit_trig = wr_en && (wr_addr == ADDR_W'(TRIG));

  always_comb begin
    start_xf   = 1'b0;
    start_kind = XF_NONE;
    if (cmd_rdy) begin
      if (hit_cmd && wr_data[0]) begin
        start_xf   = 1'b1;
        start_kind = XF_NOW;
      end else if (hit_cmd && wr_data[1]) begin
        start_xf   = 1'b1;
        start_kind = XF_EOC;
      end else if (hit_trig && mode_q[0]) begin
        start_xf   = 1'b1;
        start_kind = XF_EOC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      run_req <= 1'b0;
      xf_req  <= 1'b0;
      xf_kind <= XF_NONE;
      mode_q  <= '0;
    end else begin
      if (hit_run && run_rdy && (wr_data[0] != run_q)) begin
        run_q   <= wr_data[0];
        run_req <= ~run_req;
      end
      if (start_xf) begin
        xf_kind <= start_kind;
        xf_req  <= ~xf_req;
      end
      if (hit_mode && !run_q) mode_q <= wr_data;
    end
  end

  for (genvar i = 0; i < NBYTE; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else if (wr_en && cmd_rdy && (wr_addr == ADDR_W'(CMP_BASE + i)))
        stage_q[i] <= wr_data;
    end
    assign stage_flat[8*i +: 8] = stage_q[i];
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(A_RUN):  rd_data = {7'b0, run_q};
      ADDR_W'(A_CMD):  rd_data = xf_busy ? {6'b0, xf_kind} : 8'h00;
      ADDR_W'(A_STAT): rd_data = {5'b0, run_q, cmd_rdy, run_rdy};
      ADDR_W'(A_MODE): rd_data = mode_q;
      default: begin
        for (int i = 0; i < NBYTE; i++)
          if (rd_addr == ADDR_W'(CMP_BASE + i)) rd_data = stage_q[i];
      end
    endcase
  end

  a_r2_run_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !run_rdy |=> $stable(run_q));
  a_r4_stage_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rdy |=> $stable(stage_flat));
  a_r9_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(mode_q));
  a_r8_one_flight: assert property (@(posedge clk) disable iff (!rst_n)
    xf_busy |=> $stable(xf_kind));
endmodule

// File: rtl/xdb_core_side.sv
module xdb_core_side
  import xdb_pkg::*;
#(
  parameter int NCMP  = 4,
  parameter int CMP_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_req_s,
  input  logic                  xf_req_s,
  input  logic                  run_bus,
  input  xfer_e                 xf_kind,
  input  logic [NCMP*CMP_W-1:0] stage_flat,
  input  logic                  eoc_i,
  output logic                  run_ack,
  output logic                  xf_ack,
  output logic                  core_run_q,
  output logic [NCMP*CMP_W-1:0] shadow_q
);
  logic run_new, xf_new, pend_q;
  logic load_on, load_now, load_eoc;

  assign run_new  = run_req_s ^ run_ack;
  assign xf_new   = (xf_req_s ^ xf_ack) && !pend_q;
  assign load_on  = run_new && run_bus;
  assign load_now = xf_new && (xf_kind == XF_NOW);
  assign load_eoc = pend_q && eoc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_ack    <= 1'b0;
      xf_ack     <= 1'b0;
      pend_q     <= 1'b0;
      core_run_q <= 1'b0;
    end else begin
      if (run_new) begin
        core_run_q <= run_bus;
        run_ack    <= ~run_ack;
      end
      if (load_now) xf_ack <= ~xf_ack;
      else if (xf_new) pend_q <= 1'b1;
      if (load_eoc) begin
        pend_q <= 1'b0;
        xf_ack <= ~xf_ack;
      end
    end
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow_q[k*CMP_W +: CMP_W] <= '0;
      else if (load_on || load_now || load_eoc)
        shadow_q[k*CMP_W +: CMP_W] <= stage_flat[k*CMP_W +: CMP_W];
    end
  end

  a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !eoc_i |=> $stable(shadow_q));
  a_r6_pending_running: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> core_run_q);
  a_r10_off_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    run_new && !run_bus |=> $stable(shadow_q));
endmodule

// File: rtl/xdom_regbank.sv
module xdom_regbank
  import xdb_pkg::*;
#(
  parameter int NCMP   = 4,
  parameter int CMP_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                  bus_clk,
  input  logic                  core_clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  input  logic                  core_eoc,
  output logic                  core_run,
  output logic [NCMP*CMP_W-1:0] core_cmp,
  output logic [7:0]            cfg_mode
);
  logic run_req, xf_req, run_ack, xf_ack, run_q;
  logic [1:0] req_s, ack_s;
  xfer_e xf_kind;
  logic [NCMP*CMP_W-1:0] stage_flat;

  xdb_bus_side #(.NCMP(NCMP), .CMP_W(CMP_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(bus_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .run_ack_s(ack_s[0]), .xf_ack_s(ack_s[1]),
    .run_req(run_req), .xf_req(xf_req), .run_q(run_q),
    .xf_kind(xf_kind), .stage_flat(stage_flat), .mode_q(cfg_mode)
  );

  xdb_sync #(.W(2)) u_to_core (
    .clk(core_clk), .rst_n(rst_n), .d({xf_req, run_req}), .q(req_s)
  );

  xdb_sync #(.W(2)) u_to_bus (
    .clk(bus_clk), .rst_n(rst_n), .d({xf_ack, run_ack}), .q(ack_s)
  );

  xdb_core_side #(.NCMP(NCMP), .CMP_W(CMP_W)) u_core (
    .clk(core_clk), .rst_n(rst_n),
    .run_req_s(req_s[0]), .xf_req_s(req_s[1]),
    .run_bus(run_q), .xf_kind(xf_kind), .stage_flat(stage_flat),
    .eoc_i(core_eoc), .run_ack(run_ack), .xf_ack(xf_ack),
    .core_run_q(core_run), .shadow_q(core_cmp)
  );
endmodule

// File: tb/xdom_regbank_test.sv
module xdom_regbank_test;
  localparam int CLK_PERIOD  = 10;
  localparam int CCLK_PERIOD = 13;
  localparam int NBYTE = 8;

  logic bus_clk = 0, core_clk = 0, rst_n = 0;
  logic wr_en = 0, core_eoc = 0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data, cfg_mode;
  logic core_run;
  logic [63:0] core_cmp;

  int checks = 0, errors = 0;
  logic [7:0] exp_stage [NBYTE];
  logic [63:0] exp_shadow;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  always #(CCLK_PERIOD/2.0) core_clk = ~core_clk;

  xdom_regbank uut (
    .bus_clk(bus_clk), .core_clk(core_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .core_eoc(core_eoc),
    .core_run(core_run), .core_cmp(core_cmp), .cfg_mode(cfg_mode)
  );

  function automatic logic [63:0] pack_stage();
    logic [63:0] v;
    for (int i = 0; i < NBYTE; i++) v[8*i +: 8] = exp_stage[i];
    return v;
  endfunction

  function automatic logic [7:0] stat_of(bit run, bit crdy, bit rrdy);
    return {5'b0, run, crdy, rrdy};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge bus_clk);
    wr_en = 1; wr_addr = 5'(a); wr_data = d;
    @(negedge bus_clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge bus_clk);
    rd_addr = 5'(a);
    #1 d = rd_data;
  endtask

  task automatic wait_bit(int b, string tag);
    logic [7:0] s;
    for (int n = 0; n < 300; n++) begin
      rd(2, s);
      if (s[b]) return;
    end
    chk(0, tag, 0, 1);
  endtask

  task automatic eoc_pulse();
    @(negedge core_clk); core_eoc = 1;
    @(negedge core_clk); core_eoc = 0;
  endtask

  task automatic rand_writes(int n, bit accept, bit allow_trig);
    for (int k = 0; k < n; k++) begin
      int a;
      logic [7:0] d;
      a = 8 + int'($urandom % 8);
      if (!allow_trig && a == 15) a = 14;
      d = 8'($urandom);
      wr(a, d);
      if (accept) exp_stage[a-8] = d;
    end
  endtask

  task automatic check_stage(string tag);
    logic [7:0] d;
    for (int i = 0; i < NBYTE; i++) begin
      rd(8 + i, d);
      chk(d == exp_stage[i], tag, d, exp_stage[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NBYTE; i++) exp_stage[i] = '0;
    exp_shadow = '0;
    repeat (3) @(negedge bus_clk);
    rst_n = 1;

    // R1 reset state
    rd(2, rv); chk(rv == stat_of(0, 0, 1), "R1 status", rv, stat_of(0, 0, 1));
    rd(0, rv); chk(rv == 0, "R1 run", rv, 0);
    rd(1, rv); chk(rv == 0, "R1 cmd", rv, 0);
    chk(core_cmp == 0 && !core_run, "R1 core", {core_run, core_cmp[62:0]}, 0);

    // R4 writes while disabled are dropped; R9 mode writable while off
    rand_writes(6, 0, 1);
    check_stage("R4 disabled write");
    wr(3, 8'h5A);
    rd(3, rv); chk(rv == 8'h5A, "R9 mode off", rv, 8'h5A);

    // R3 enable, R2 run write while busy ignored
    wr(0, 1);
    rd(2, rv); chk(rv[0] == 0, "R3 run-ready low", rv, 0);
    wr(0, 0);
    wait_bit(0, "R3 run-ready timeout");
    rd(0, rv); chk(rv == 1, "R2 busy write ignored", rv, 1);
    chk(core_run == 1, "R3 core_run", core_run, 1);
    rd(2, rv); chk(rv == stat_of(1, 1, 1), "R3 status", rv, stat_of(1, 1, 1));

    // R9 locked while running
    wr(3, 8'hFF);
    rd(3, rv); chk(rv == 8'h5A, "R9 mode locked", rv, 8'h5A);

    // R7 auto-update off: writes incl. address 15 start nothing
    rand_writes(20, 1, 1);
    wr(15, 8'hC3); exp_stage[7] = 8'hC3;
    rd(2, rv); chk(rv[1] == 1, "R7 no auto transfer", rv, 1);
    check_stage("R4 accepted write");
    chk(core_cmp == exp_shadow, "R7 shadow unchanged", core_cmp, exp_shadow);

    // R5 immediate transfer, R8 readback, R4 write during busy ignored
    wr(1, 8'h01);
    rd(1, rv); chk(rv == 8'h01, "R8 cmd readback now", rv, 1);
    wr(9, ~exp_stage[1]);
    wait_bit(1, "R5 cmd-ready timeout");
    exp_shadow = pack_stage();
    check_stage("R4 busy write ignored");
    chk(core_cmp == exp_shadow, "R5 shadow update", core_cmp, exp_shadow);
    rd(1, rv); chk(rv == 0, "R8 cmd cleared", rv, 0);

    // R6 end-of-cycle transfer
    rand_writes(10, 1, 0);
    wr(1, 8'h02);
    repeat (30) @(negedge core_clk);
    chk(core_cmp == exp_shadow, "R6 hold before eoc", core_cmp, exp_shadow);
    rd(1, rv); chk(rv == 8'h02, "R8 cmd readback eoc", rv, 2);
    rd(2, rv); chk(rv == stat_of(1, 0, 0), "R6 status busy", rv, stat_of(1, 0, 0));
    wr(1, 8'h01);
    wr(0, 0);
    rd(1, rv); chk(rv == 8'h02, "R8 cmd write ignored", rv, 2);
    rd(0, rv); chk(rv == 1, "R2 run write ignored", rv, 1);
    chk(core_cmp == exp_shadow, "R8 no extra transfer", core_cmp, exp_shadow);
    eoc_pulse();
    wait_bit(1, "R6 cmd-ready timeout");
    exp_shadow = pack_stage();
    chk(core_cmp == exp_shadow, "R6 shadow after eoc", core_cmp, exp_shadow);

    // R10 disable keeps shadows; R3 enable copies staging
    rand_writes(8, 1, 0);
    wr(0, 0);
    wait_bit(0, "R10 run-ready timeout");
    chk(core_run == 0, "R10 core_run", core_run, 0);
    chk(core_cmp == exp_shadow, "R10 shadows kept", core_cmp, exp_shadow);
    wr(3, 8'h01);
    rd(3, rv); chk(rv == 8'h01, "R9 mode set", rv, 1);
    wr(0, 1);
    wait_bit(0, "R3 enable timeout");
    exp_shadow = pack_stage();
    chk(core_cmp == exp_shadow, "R3 enable copy", core_cmp, exp_shadow);

    // R7 auto-update on
    wr(14, 8'h11); exp_stage[6] = 8'h11;
    rd(2, rv); chk(rv[1] == 1, "R7 low byte no trigger", rv, 1);
    wr(15, 8'h22); exp_stage[7] = 8'h22;
    rd(1, rv); chk(rv == 8'h02, "R7 auto readback", rv, 2);
    repeat (20) @(negedge core_clk);
    chk(core_cmp == exp_shadow, "R7 hold before eoc", core_cmp, exp_shadow);
    eoc_pulse();
    wait_bit(1, "R7 cmd-ready timeout");
    exp_shadow = pack_stage();
    chk(core_cmp == exp_shadow, "R7 auto shadow", core_cmp, exp_shadow);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule